// File: doc/BRIEF.md
# 32-bit Eight-Function ALU

This block is the combinational arithmetic and logic unit of a small multicycle processor. It takes two 32-bit operands, `a_i` and `b_i`, and a 3-bit function select. It returns a 32-bit result together with two status flags. The control path uses these flags to resolve conditional branches. A branch runs the subtract function and then makes its decision from the flags: equal and not-equal branches use the zero flag, and the branch-if-negative uses the sign flag.

The functions are add, subtract, logical left shift, OR, AND, XOR, an unsigned less-than and a signed less-than. The shift is unusual in one way: `b_i` holds the data and the low five bits of `a_i` hold the shift count. The signed compare is built from the unsigned compare and the two operand sign bits, and does not use a second subtractor. The block holds no state and has no clock. Its results settle within the same cycle and are registered by the processor datapath around it.

Top module: `alu32`

## Requirements
- R1: Select 3'b000 gives y_o = a_i + b_i modulo 2^32.
- R2: Select 3'b001 gives y_o = a_i - b_i modulo 2^32.
- R3: Select 3'b010 gives y_o = b_i shifted left logically by a_i[4:0], with zeros shifted in. Bits 31..5 of a_i have no effect, so a count of 32 or more wraps to its low five bits.
- R4: Select 3'b011 gives the bitwise OR, 3'b100 gives the bitwise AND, and 3'b111 gives the bitwise XOR of a_i and b_i.
- R5: Select 3'b101 gives y_o = 1 when a_i < b_i as unsigned numbers, and 0 otherwise.
- R6: Select 3'b110 gives y_o = 1 when a_i < b_i as two's-complement numbers, and 0 otherwise. A negative a_i with a non-negative b_i always gives 1.
- R7: For selects 3'b101 and 3'b110, bits 31..1 of y_o are 0.
- R8: zero_o is 1 exactly when all 32 bits of y_o are 0.
- R9: sign_o always equals y_o[31].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand; its low five bits are the shift count |
| b_i | input | 32 | Second operand; the shift data |
| op_i | input | 3 | Function select |
| y_o | output | 32 | Result |
| zero_o | output | 1 | High when the result is all zeros |
| sign_o | output | 1 | Most significant bit of the result |

## Verification
The embedded assertions assume that `op_i`, `a_i` and `b_i` are fully known, two-state values. They also assume they are checked only once the combinational paths have settled. The bench keeps to this in two ways: it changes inputs only on the falling clock edge, and it samples one nanosecond later. Inside that window the stimulus covers every select code. It crosses a set of boundary operands: zero, one, the values around 31 and 32, the largest positive and most negative numbers, and all ones. A pseudo-random sweep then adds further operand pairs for every select.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int unsigned DATA_W = 32;

    typedef enum logic [2:0] {
        FN_ADD  = 3'b000,
        FN_SUB  = 3'b001,
        FN_SHL  = 3'b010,
        FN_OR   = 3'b011,
        FN_AND  = 3'b100,
        FN_ULT  = 3'b101,
        FN_SLT  = 3'b110,
        FN_XOR  = 3'b111
    } alu_fn_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o
);
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        sum_o = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
    end
endmodule

// File: rtl/alu_shl.sv
module alu_shl #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]         data_i,
    input  logic [$clog2(W)-1:0] amt_i,
    output logic [W-1:0]         res_o
);
    localparam int unsigned STAGES = $clog2(W);

    logic [W-1:0] stage [STAGES+1];

    assign stage[0] = data_i;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            assign stage[s+1] = amt_i[s] ? (stage[s] << (1 << s)) : stage[s];
        end
    endgenerate

    assign res_o = stage[STAGES];
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         ult_o,
    output logic         slt_o
);
    logic a_neg;
    logic b_neg;

    always_comb begin
        a_neg = a_i[W-1];
        b_neg = b_i[W-1];
        ult_o = (a_i < b_i);
        slt_o = (a_neg & ~b_neg) | ((a_neg == b_neg) & ult_o);
    end
endmodule

// File: rtl/alu32.sv
module alu32
    import alu_pkg::*;
(
    input  logic [31:0] a_i,
    input  logic [31:0] b_i,
    input  logic [2:0]  op_i,
    output logic [31:0] y_o,
    output logic        zero_o,
    output logic        sign_o
);
    localparam int unsigned W   = DATA_W;
    localparam int unsigned SHW = $clog2(W);

    alu_fn_e      fn;
    logic [W-1:0] arith_res;
    logic [W-1:0] shl_res;
    logic         ult;
    logic         slt;

    assign fn = alu_fn_e'(op_i);

    alu_addsub #(.W(W)) u_addsub (
        .a_i   (a_i),
        .b_i   (b_i),
        .sub_i (fn == FN_SUB),
        .sum_o (arith_res)
    );

    alu_shl #(.W(W)) u_shl (
        .data_i (b_i),
        .amt_i  (a_i[SHW-1:0]),
        .res_o  (shl_res)
    );

    alu_cmp #(.W(W)) u_cmp (
        .a_i   (a_i),
        .b_i   (b_i),
        .ult_o (ult),
        .slt_o (slt)
    );

    always_comb begin
        unique case (fn)
            FN_ADD, FN_SUB: y_o = arith_res;
            FN_SHL:         y_o = shl_res;
            FN_OR:          y_o = a_i | b_i;
            FN_AND:         y_o = a_i & b_i;
            FN_ULT:         y_o = {{(W-1){1'b0}}, ult};
            FN_SLT:         y_o = {{(W-1){1'b0}}, slt};
            FN_XOR:         y_o = a_i ^ b_i;
            default:        y_o = '0;
        endcase
    end

    assign zero_o = (y_o == '0);
    assign sign_o = y_o[W-1];

    // Checks on settled combinational values
    always_comb begin
        if (fn == FN_ULT || fn == FN_SLT) begin
            a_r7_cmp_upper_clear: assert (y_o[W-1:1] == '0)
                else $error("R7 compare result has upper bits set");
        end
        if (fn == FN_SLT && (a_i[W-1] != b_i[W-1])) begin
            a_r6_mixed_sign: assert (y_o[0] == a_i[W-1])
                else $error("R6 mixed-sign compare wrong");
        end
        if (fn == FN_SUB && a_i == b_i) begin
            a_r2_equal_sub_zero: assert (zero_o)
                else $error("R2 equal operands did not give zero");
        end
        if (fn == FN_AND) begin
            a_r4_and_subset: assert ((y_o & ~a_i) == '0 && (y_o & ~b_i) == '0)
                else $error("R4 AND result outside operands");
        end
        a_r8_zero_no_sign: assert (!(zero_o && sign_o))
            else $error("R8 zero and sign both set");
        if (fn == FN_SHL && a_i[SHW-1:0] == '0) begin
            a_r3_shift_zero_pass: assert (y_o == b_i)
                else $error("R3 zero-count shift changed data");
        end
    end
endmodule

// File: tb/tb_alu32.sv
module tb_alu32;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a, b;
    logic [2:0]  op;
    logic [31:0] y;
    logic        zero, sign;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    alu32 dut (
        .a_i    (a),
        .b_i    (b),
        .op_i   (op),
        .y_o    (y),
        .zero_o (zero),
        .sign_o (sign)
    );

    function automatic string tag_of(input logic [2:0] f);
        case (f)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010: return "R3";
            3'b101: return "R5";
            3'b110: return "R6";
            default: return "R4";
        endcase
    endfunction

    function automatic logic [31:0] model(input logic [2:0] f, input logic [31:0] x, input logic [31:0] z);
        case (f)
            3'b000: return x + z;
            3'b001: return x - z;
            3'b010: return z << x[4:0];
            3'b011: return x | z;
            3'b100: return x & z;
            3'b101: return (x < z) ? 32'd1 : 32'd0;
            3'b110: return ($signed(x) < $signed(z)) ? 32'd1 : 32'd0;
            default: return x ^ z;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", req, op, a, b, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] f, input logic [31:0] x, input logic [31:0] z);
        logic [31:0] e;
        @(negedge clk);
        op = f; a = x; b = z;
        #1;
        e = model(f, x, z);
        check(tag_of(f), y, e);
        if (f == 3'b101 || f == 3'b110) check("R7", {1'b0, y[31:1]}, 32'd0);
        check("R8", {31'd0, zero}, {31'd0, (e == 32'd0)});
        check("R9", {31'd0, sign}, {31'd0, e[31]});
    endtask

    logic [31:0] corners [12];

    initial begin
        corners[0]  = 32'h0000_0000; corners[1]  = 32'h0000_0001;
        corners[2]  = 32'h0000_001F; corners[3]  = 32'h0000_0020;
        corners[4]  = 32'h0000_0021; corners[5]  = 32'h7FFF_FFFF;
        corners[6]  = 32'h8000_0000; corners[7]  = 32'h8000_0001;
        corners[8]  = 32'hFFFF_FFFF; corners[9]  = 32'hFFFF_FFFE;
        corners[10] = 32'h1234_5678; corners[11] = 32'hC000_0025;
        op = 3'b000; a = '0; b = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle inputs: add of zeros gives zero result, zero flag set (R1, R8)
        @(negedge clk); #1;
        check("R1", y, 32'd0);
        check("R8", {31'd0, zero}, 32'd1);
        // Boundary cross-product over all selects
        for (int f = 0; f < 8; f++)
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 12; j++)
                    apply(3'(f), corners[i], corners[j]);
        // R3: upper count bits ignored
        apply(3'b010, 32'hFFFF_FFE4, 32'h0000_00FF);
        apply(3'b010, 32'h0000_0040, 32'hDEAD_BEEF);
        // Pseudo-random sweep
        begin
            logic [31:0] s;
            s = 32'hACE1_2345;
            for (int k = 0; k < 4000; k++) begin
                logic [31:0] x;
                s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
                x = s;
                s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
                apply(3'(k % 8), x, (k % 5 == 0) ? x : s);
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule